// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Register

This block holds the interrupt sources of a network controller. Three datapath events, namely a missed-frame counter wrap, a receive-collision counter wrap and the start of a frame transmission, each latch a status flag. A fourth flag is raised by the host itself through a command bit, which gives software an interrupt that is not tied to network activity. Each datapath flag has a mask bit. A masked flag stays visible in the register but does not count towards the summary. Status flags are cleared by writing ones. Mask bits are plain read/write bits. A STOP level clears the flags and leaves the masks as they are.

The register word is 12 bits wide with `N_EVT` = 3. Event k has its flag at bit 2k and its mask at bit 2k+1. This gives the missed-frame flag and mask at 0 and 1, the receive-collision flag and mask at 2 and 3, and the transmit-start flag and mask at 4 and 5. The user-interrupt flag is at bit 6 and the user command at bit 7. Bit 8 is a read-only copy of the summary. Bits 11..9 are reserved.

Each datapath flag is a two-state machine. FL_CLEAR moves to FL_SET on the event strobe (the "capture" transition). FL_SET returns to FL_CLEAR on a write-one-clear that does not meet a strobe in the same cycle (the "acknowledge" transition). Reset or STOP forces FL_CLEAR. The user interrupt is a three-state machine:
- UI_IDLE moves to UI_ARMED when the command bit is written ("request").
- UI_ARMED always moves to UI_RAISED on the next cycle ("raise").
- UI_RAISED returns to UI_IDLE on a write of one to the user flag ("acknowledge").
- Reset or STOP forces UI_IDLE ("abort").

The interrupt line is a two-state machine. IRQ_LOW and IRQ_HIGH follow the enabled summary, one register stage behind it.

Top module: `net_irq_ctrl`

## Requirements
- R1: A high `ev_strobe[k]` with STOP and software reset low sets the flag at bit 2k of `rd_data` at the next clock edge. Strobe bit 0 is the missed-frame wrap, bit 1 the receive-collision wrap and bit 2 the transmit start.
- R2: A write with a 1 at a flag position clears that flag. A 0 at a flag position leaves the flag unchanged.
- R3: When an event strobe and a write-one-clear reach the same flag in the same cycle, the flag ends up set.
- R4: While `stop` is high, all status flags and the user command bit (bit 7) are cleared at each clock edge. The mask bits keep their values.
- R5: A low `hw_rst_n` (asynchronous) or a high `sw_rst` (synchronous) clears every flag, the command bit and `irq`, and sets every mask bit to 1. `rd_data` then reads 12'h02A.
- R6: The mask bits (2k+1) take the written value on every write. A flag whose mask is 1 does not contribute to the summary.
- R7: `irq_summary` is the OR of the unmasked datapath flags and the user flag, whatever `int_en` is. The user flag has no mask.
- R8: `irq` is registered. It equals `int_en` AND `irq_summary` from the previous cycle and stays high as long as that term holds.
- R9: Writing 1 to bit 7 while idle makes bit 7 read 1 after that edge. Bit 6 (the user flag) then sets one edge later.
- R10: Writing 1 to bit 6 while it is set clears both bit 6 and bit 7. Writing 0 to bit 7 has no effect on either bit.
- R11: Bits 11..9 always read 0 and ignore writes. Bit 8 reads `irq_summary` and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| stop | input | 1 | STOP level; clears flags and command |
| int_en | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Register read value |
| ev_strobe | input | N_EVT | Datapath event pulses |
| irq | output | 1 | Registered interrupt output |
| irq_summary | output | 1 | OR of unmasked flags |

## Verification
A hardware event strobe and a host write-one-clear can reach the same flag in the same cycle. Likewise, STOP can arrive in the same cycle as fresh event strobes. The bench provokes the first case by driving a strobe and a clearing write on the same falling edge. It judges the result by reading the flag back and expecting it set. It provokes the second case by raising STOP together with all three strobes, then expects every flag and the command bit to read zero while the masks keep the values last written. A sweep over every event, both mask values and both enable values checks the flag, summary and interrupt values against expectations computed in the bench.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic {
        FL_CLEAR,
        FL_SET
    } flag_state_t;

    typedef enum logic [1:0] {
        UI_IDLE,
        UI_ARMED,
        UI_RAISED
    } ui_state_t;

    typedef enum logic {
        IRQ_LOW,
        IRQ_HIGH
    } irq_state_t;

endpackage

// File: rtl/isr_evt_flag.sv
module isr_evt_flag
    import isr_pkg::*;
(
    input  logic clk,
    input  logic hw_rst_n,
    input  logic sw_rst,
    input  logic stop,
    input  logic ev,
    input  logic clr,
    input  logic mask_we,
    input  logic mask_d,
    output logic flag,
    output logic mask
);

    flag_state_t st_q, st_nx;
    logic        mask_q;

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            st_q <= FL_CLEAR;
        end else begin
            st_q <= st_nx;
        end
    end

    // capture has priority over acknowledge so no event is lost
    always_comb begin
        st_nx = st_q;
        if (sw_rst || stop) begin
            st_nx = FL_CLEAR;
        end else begin
            unique case (st_q)
                FL_CLEAR: if (ev)         st_nx = FL_SET;
                FL_SET:   if (clr && !ev) st_nx = FL_CLEAR;
                default:                  st_nx = FL_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            mask_q <= 1'b1;
        end else if (sw_rst) begin
            mask_q <= 1'b1;
        end else if (mask_we) begin
            mask_q <= mask_d;
        end
    end

    always_comb begin
        flag = (st_q == FL_SET);
        mask = mask_q;
    end

endmodule

// File: rtl/isr_user_fsm.sv
module isr_user_fsm
    import isr_pkg::*;
(
    input  logic clk,
    input  logic hw_rst_n,
    input  logic sw_rst,
    input  logic stop,
    input  logic cmd_wr,
    input  logic ack_wr,
    output logic ucmd,
    output logic uflag
);

    ui_state_t st_q, st_nx;

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            st_q <= UI_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        st_nx = st_q;
        if (sw_rst || stop) begin
            st_nx = UI_IDLE;
        end else begin
            unique case (st_q)
                UI_IDLE:   if (cmd_wr) st_nx = UI_ARMED;
                UI_ARMED:              st_nx = UI_RAISED;
                UI_RAISED: if (ack_wr) st_nx = UI_IDLE;
                default:               st_nx = UI_IDLE;
            endcase
        end
    end

    always_comb begin
        ucmd  = (st_q != UI_IDLE);
        uflag = (st_q == UI_RAISED);
    end

endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen
    import isr_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             hw_rst_n,
    input  logic             sw_rst,
    input  logic             int_en,
    input  logic [N_SRC-1:0] pend,
    output logic             summary,
    output logic             irq
);

    irq_state_t st_q, st_nx;
    logic       any_pend;

    assign any_pend = |pend;

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            st_q <= IRQ_LOW;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        st_nx = st_q;
        if (sw_rst) begin
            st_nx = IRQ_LOW;
        end else begin
            unique case (st_q)
                IRQ_LOW:  if (int_en && any_pend)    st_nx = IRQ_HIGH;
                IRQ_HIGH: if (!(int_en && any_pend)) st_nx = IRQ_LOW;
                default:                             st_nx = IRQ_LOW;
            endcase
        end
    end

    always_comb begin
        summary = any_pend;
        irq     = (st_q == IRQ_HIGH);
    end

endmodule

// File: rtl/net_irq_ctrl.sv
module net_irq_ctrl #(
    parameter int N_EVT = 3,
    parameter int REG_W = 12
) (
    input  logic             clk,
    input  logic             hw_rst_n,
    input  logic             sw_rst,
    input  logic             stop,
    input  logic             int_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [N_EVT-1:0] ev_strobe,
    output logic             irq,
    output logic             irq_summary
);

    localparam int UF_BIT  = 2 * N_EVT;
    localparam int CMD_BIT = UF_BIT + 1;
    localparam int SUM_BIT = CMD_BIT + 1;
    localparam int N_SRC   = N_EVT + 1;

    logic [N_EVT-1:0] flag_v;
    logic [N_EVT-1:0] mask_v;
    logic [N_SRC-1:0] pend_v;
    logic             ucmd;
    logic             uflag;
    logic             wr_unused_bits;

    assign wr_unused_bits = ^wr_data[REG_W-1:SUM_BIT];

    for (genvar k = 0; k < N_EVT; k++) begin : g_evt
        isr_evt_flag u_flag (
            .clk     (clk),
            .hw_rst_n(hw_rst_n),
            .sw_rst  (sw_rst),
            .stop    (stop),
            .ev      (ev_strobe[k]),
            .clr     (wr_en && wr_data[2*k]),
            .mask_we (wr_en),
            .mask_d  (wr_data[2*k+1]),
            .flag    (flag_v[k]),
            .mask    (mask_v[k])
        );
        assign pend_v[k] = flag_v[k] && !mask_v[k];
    end

    isr_user_fsm u_user (
        .clk     (clk),
        .hw_rst_n(hw_rst_n),
        .sw_rst  (sw_rst),
        .stop    (stop),
        .cmd_wr  (wr_en && wr_data[CMD_BIT]),
        .ack_wr  (wr_en && wr_data[UF_BIT]),
        .ucmd    (ucmd),
        .uflag   (uflag)
    );

    assign pend_v[N_EVT] = uflag;

    isr_irq_gen #(.N_SRC(N_SRC)) u_irq (
        .clk     (clk),
        .hw_rst_n(hw_rst_n),
        .sw_rst  (sw_rst),
        .int_en  (int_en),
        .pend    (pend_v),
        .summary (irq_summary),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_EVT; k++) begin
            rd_data[2*k]   = flag_v[k];
            rd_data[2*k+1] = mask_v[k];
        end
        rd_data[UF_BIT]  = uflag;
        rd_data[CMD_BIT] = ucmd;
        rd_data[SUM_BIT] = irq_summary;
    end

endmodule

// File: rtl/net_irq_ctrl_chk.sv
module net_irq_ctrl_chk #(
    parameter int N_EVT = 3,
    parameter int REG_W = 12
) (
    input logic             clk,
    input logic             hw_rst_n,
    input logic             sw_rst,
    input logic             stop,
    input logic             int_en,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [N_EVT-1:0] ev_strobe,
    input logic             irq,
    input logic             irq_summary
);

    localparam int UF_BIT  = 2 * N_EVT;
    localparam int CMD_BIT = UF_BIT + 1;
    localparam int SUM_BIT = CMD_BIT + 1;

    for (genvar k = 0; k < N_EVT; k++) begin : g_chk
        // R1
        evt_set_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
            (ev_strobe[k] && !stop && !sw_rst) |=> rd_data[2*k]);
        // R4
        stop_clr_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
            stop |=> !rd_data[2*k]);
        // R5
        mask_rst_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
            sw_rst |=> rd_data[2*k+1]);
    end

    // R4
    stop_cmd_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        stop |=> !rd_data[CMD_BIT] && !rd_data[UF_BIT]);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (int_en && irq_summary && !sw_rst) |=> irq);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !(int_en && irq_summary) |=> !irq);

    // R10
    user_ack_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (wr_en && wr_data[UF_BIT] && rd_data[UF_BIT]) |=> !rd_data[CMD_BIT]);

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        rd_data[REG_W-1:SUM_BIT+1] == '0);

endmodule

bind net_irq_ctrl net_irq_ctrl_chk #(.N_EVT(N_EVT), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .hw_rst_n   (hw_rst_n),
    .sw_rst     (sw_rst),
    .stop       (stop),
    .int_en     (int_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .ev_strobe  (ev_strobe),
    .irq        (irq),
    .irq_summary(irq_summary)
);

// File: tb/sim_net_irq_ctrl.sv
`timescale 1ns/1ps
module sim_net_irq_ctrl;

    logic        clk = 1'b0;
    logic        hw_rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        stop = 1'b0;
    logic        int_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic [2:0]  ev_strobe = '0;
    logic        irq;
    logic        irq_summary;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    net_irq_ctrl #(.N_EVT(3), .REG_W(12)) u0 (
        .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .stop(stop),
        .int_en(int_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_strobe(ev_strobe), .irq(irq), .irq_summary(irq_summary)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        hw_rst_n = 1'b1;
        chk("R5 reset value", rd_data, 12'h02A);
        chk("R5 reset irq", irq, 0);
        chk("R7 reset summary", irq_summary, 0);

        // sweep over event, mask value and enable
        for (int i = 0; i < 3; i++) begin
            for (int m = 0; m < 2; m++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [11:0] cfg;
                    logic        exp_pend;
                    cfg = 12'h07F;
                    cfg[2*i+1] = m[0];
                    exp_pend = (m == 0);
                    int_en = en[0];
                    wr(cfg);
                    tick();
                    chk("R2 flags cleared", rd_data & 12'h055, 0);
                    chk("R8 idle irq", irq, 0);
                    ev_strobe[i] = 1'b1;
                    tick();
                    ev_strobe = '0;
                    chk("R1 flag set", rd_data[2*i], 1);
                    chk("R6 mask readback", rd_data[2*i+1], m[0]);
                    chk("R7 summary", irq_summary, exp_pend);
                    chk("R11 summary bit", rd_data[8], exp_pend);
                    chk("R8 irq lag", irq, 0);
                    tick();
                    chk("R8 irq level", irq, exp_pend && (en == 1));
                    tick();
                    chk("R8 irq held", irq, exp_pend && (en == 1));
                    wr(12'h001 << (2*i) | cfg & 12'h02A);
                    chk("R2 w1c", rd_data[2*i], 0);
                    chk("R7 summary cleared", irq_summary, 0);
                end
            end
        end

        // R2: zeros leave flags alone
        int_en = 1'b1;
        wr(12'h07F);
        ev_strobe = 3'b111;
        tick();
        ev_strobe = '0;
        wr(12'h02A);
        chk("R2 zero write keeps flags", rd_data & 12'h015, 12'h015);

        // R3: strobe and clear in the same cycle
        wr(12'h03F);
        chk("R3 pre clear", rd_data & 12'h015, 0);
        ev_strobe = 3'b010;
        wr_en = 1'b1;
        wr_data = 12'h03F;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
        ev_strobe = '0;
        chk("R3 set wins", rd_data & 12'h015, 12'h004);

        // R4: stop with simultaneous events
        wr(12'h015);
        ev_strobe = 3'b111;
        tick();
        ev_strobe = '0;
        wr(12'h080);
        tick();
        chk("R9 user raised", rd_data[7:6], 2'b11);
        stop = 1'b1;
        ev_strobe = 3'b111;
        tick();
        stop = 1'b0;
        ev_strobe = '0;
        chk("R4 stop clears, masks kept", rd_data, 12'h000);
        tick();
        chk("R4 stays clear", rd_data, 12'h000);
        chk("R8 irq drops after stop", irq, 0);

        // R9 / R10: user interrupt
        wr(12'h080);
        chk("R9 cmd set", rd_data[7], 1);
        chk("R9 flag not yet", rd_data[6], 0);
        tick();
        chk("R9 flag set", rd_data[6], 1);
        chk("R7 user summary", irq_summary, 1);
        tick();
        chk("R8 user irq", irq, 1);
        wr(12'h000);
        chk("R10 zero to cmd ignored", rd_data[7:6], 2'b11);
        wr(12'h040);
        chk("R10 ack clears both", rd_data[7:6], 2'b00);
        chk("R10 summary gone", irq_summary, 0);
        tick();
        chk("R8 irq gone", irq, 0);

        // R11: reserved and summary bits
        wr(12'hFFF);
        chk("R11 reserved zero", rd_data[11:9], 0);
        chk("R11 all-ones write", rd_data, 12'h0AA);
        tick();
        chk("R11 summary read-only", rd_data, 12'h1EA);

        // R5: software reset
        ev_strobe = 3'b111;
        tick();
        ev_strobe = '0;
        wr(12'h080);
        tick();
        chk("R8 pre reset irq", irq, 1);
        sw_rst = 1'b1;
        tick();
        sw_rst = 1'b0;
        chk("R5 sw reset value", rd_data, 12'h02A);
        chk("R5 sw reset irq", irq, 0);

        // R5: hardware reset mid-run
        ev_strobe = 3'b111;
        tick();
        ev_strobe = '0;
        wr(12'h000);
        tick();
        hw_rst_n = 1'b0;
        #1;
        chk("R5 hw reset value", rd_data, 12'h02A);
        chk("R5 hw reset irq", irq, 0);
        @(negedge clk);
        hw_rst_n = 1'b1;
        tick();
        chk("R5 after hw reset", rd_data, 12'h02A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule